// File: doc/BRIEF.md
# Tile Background Scanline Renderer

This block draws one scanline of a tiled background. The screen is 256 pixels wide and 240 lines tall, built from 8x8 tiles: 32 columns and 30 rows. For each tile on the line, the block reads four bytes:

- the tile number, from the name area of a 1 KiB map page;
- a colour-group byte, from the 64 bytes at the top of that same page;
- two pattern bytes, one per bit plane, from one of two 4 KiB pattern banks.

It then turns each tile into eight pixel colour indices, left pixel first. Each index is emitted with a valid strobe.

A controller pulses `start` with the line number and the pattern bank select. Both memories are synchronous-read: the renderer drives an address with a read enable, and the byte comes back on the next cycle.

One attribute byte covers a 4x4 group of tiles and holds four 2-bit fields, one per 2x2 quadrant. The field for a tile is chosen by bit 1 of its row and bit 1 of its column. A pixel whose two pattern bits are both zero is transparent, and the latched backdrop index is shown in its place.

The next tile is fetched while the current one is shifted out. After an 8-cycle prefetch, the line streams one pixel per clock with no gaps.

Top module: `tile_bg_render`

## Requirements
- R1: While `rst` is high, the outputs `pix_valid`, `busy`, `nt_rd` and `pt_rd` are all low.
- R2: A `start` pulse accepted at a clock edge starts the line. `pix_valid` rises exactly 9 edges later. It then stays high for 256 consecutive cycles while `pix_x` counts 0 to 255, and then falls. `busy` is high from the edge after the accepted `start` until the last pixel has been shown.
- R3: The tile number for column c on row r = line_y/8 is read from name address r*32 + c.
- R4: The colour-group byte for the tile is read from name address 960 + (r/4)*8 + c/4. The tile's 2-bit field sits at bit offset 4*bit1(r) + 2*bit1(c) within that byte.
- R5: The pattern bytes are read at pattern address pat_sel*4096 + tile*16 + (line_y mod 8) for plane 0, and at that address + 8 for plane 1. Bit 7 of each byte is the leftmost pixel.
- R6: `pix_idx` is {field[1:0], plane1 bit, plane0 bit} when either pattern bit is 1. When both are 0 it equals the `backdrop` value latched at `start`.
- R7: A `start` pulse while `busy` is high is ignored. So are changes to `line_y`, `pat_sel` or `backdrop` after the line has started. The pixel stream of the running line is unchanged.
- R8: Each line makes exactly 64 name-port reads and 64 pattern-port reads. The two ports never read in the same cycle. For each tile, the name-port reads come directly before its pattern-port reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to render one line; ignored while busy |
| line_y | input | 8 | Line number, 0 to 239 |
| pat_sel | input | 1 | Pattern bank select |
| backdrop | input | 4 | Colour index for transparent pixels |
| nt_rd | output | 1 | Name/attribute memory read enable |
| nt_addr | output | 10 | Name/attribute memory address |
| nt_data | input | 8 | Name/attribute read data, one cycle after `nt_rd` |
| pt_rd | output | 1 | Pattern memory read enable |
| pt_addr | output | 13 | Pattern memory address |
| pt_data | input | 8 | Pattern read data, one cycle after `pt_rd` |
| busy | output | 1 | A line is in progress |
| pix_valid | output | 1 | `pix_x` and `pix_idx` hold a pixel |
| pix_x | output | 8 | Pixel column |
| pix_idx | output | 4 | Pixel palette index |

## Verification
The memory models return a hash of the address, so a wrong name, attribute or pattern address produces wrong pixel indices across the whole line. The chosen lines cover:

- rows 0 and 29;
- a row whose bit 1 is set, which needs the upper attribute fields;
- both pattern banks;
- a backdrop whose low bits are non-zero, so a transparent pixel that leaked pattern or attribute bits would show.

The timing check counts edges from `start` to the first pixel and across the 256-pixel run. An off-by-one pipeline or a missed shift-register load would show as a gap or a repeated pixel. A restart pulse in mid-line, sent with a different line and bank, catches a design that re-latches its inputs while busy.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

    localparam int TILE_PX   = 8;
    localparam int TILES_X   = 32;
    localparam int TILES_Y   = 30;
    localparam int ATTR_GRP  = 4;
    localparam int PAL_W     = 4;
    localparam int BYTE_W    = 8;
    localparam int NT_AW     = 10;
    localparam int PT_AW     = 13;

    localparam int LINES     = TILES_Y * TILE_PX;
    localparam int LINE_PX   = TILES_X * TILE_PX;
    localparam int ATTR_BASE = TILES_X * TILES_Y;
    localparam int ATTR_COLS = TILES_X / ATTR_GRP;
    localparam int PH_W      = $clog2(TILE_PX);
    localparam int COL_W     = $clog2(TILES_X);
    localparam int ROW_W     = $clog2(TILES_Y);
    localparam int X_W       = $clog2(LINE_PX);
    localparam int Y_W       = $clog2(LINES);
    localparam int CNT_LAST  = LINE_PX + TILE_PX - 1;
    localparam int CNT_W     = $clog2(CNT_LAST + 1);

    localparam logic [PH_W-1:0] PH_NAME  = PH_W'(0);
    localparam logic [PH_W-1:0] PH_ATTR  = PH_W'(1);
    localparam logic [PH_W-1:0] PH_LO    = PH_W'(2);
    localparam logic [PH_W-1:0] PH_HI    = PH_W'(3);
    localparam logic [PH_W-1:0] PH_GOTHI = PH_W'(4);
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(TILE_PX - 1);

    typedef struct packed {
        logic [1:0]        pal;
        logic [BYTE_W-1:0] plane0;
        logic [BYTE_W-1:0] plane1;
    } tile_row_t;

    function automatic logic [NT_AW-1:0] name_addr(input logic [ROW_W-1:0] row,
                                                   input logic [COL_W-1:0] col);
        return NT_AW'(row) * NT_AW'(TILES_X) + NT_AW'(col);
    endfunction

    function automatic logic [NT_AW-1:0] group_addr(input logic [ROW_W-1:0] row,
                                                    input logic [COL_W-1:0] col);
        return NT_AW'(ATTR_BASE) + NT_AW'(row / ROW_W'(ATTR_GRP)) * NT_AW'(ATTR_COLS)
             + NT_AW'(col / COL_W'(ATTR_GRP));
    endfunction

    function automatic logic [1:0] group_field(input logic [BYTE_W-1:0] grp,
                                               input logic row_b1,
                                               input logic col_b1);
        logic [2:0] sh;
        sh = {row_b1, col_b1, 1'b0};
        return 2'(grp >> sh);
    endfunction

    function automatic logic [PT_AW-1:0] pat_addr(input logic bank,
                                                  input logic [BYTE_W-1:0] tile,
                                                  input logic plane,
                                                  input logic [PH_W-1:0] fine);
        return {bank, tile, plane, fine};
    endfunction

endpackage

// File: rtl/tbr_seq.sv
module tbr_seq
    import tbr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    output logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             fetch_en,
    output logic [PH_W-1:0]  phase,
    output logic [COL_W-1:0] col,
    output logic             emit_en,
    output logic             load
);

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (!run) begin
            if (go) begin
                run <= 1'b1;
                cnt <= '0;
            end
        end else if (cnt == CNT_W'(CNT_LAST)) begin
            run <= 1'b0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign phase    = cnt[PH_W-1:0];
    assign col      = cnt[PH_W +: COL_W];
    assign fetch_en = run && (cnt < CNT_W'(LINE_PX));
    assign emit_en  = run && (cnt >= CNT_W'(TILE_PX));
    assign load     = fetch_en && (phase == PH_LAST);

endmodule

// File: rtl/tbr_fetch.sv
module tbr_fetch
    import tbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_en,
    input  logic [PH_W-1:0]   phase,
    input  logic [COL_W-1:0]  col,
    input  logic [ROW_W-1:0]  row,
    input  logic [PH_W-1:0]   fine,
    input  logic              bank,
    output logic              nt_rd,
    output logic [NT_AW-1:0]  nt_addr,
    input  logic [BYTE_W-1:0] nt_data,
    output logic              pt_rd,
    output logic [PT_AW-1:0]  pt_addr,
    input  logic [BYTE_W-1:0] pt_data,
    output tile_row_t         fetched
);

    logic [BYTE_W-1:0] tile_q;

    always_comb begin
        nt_rd   = fetch_en && (phase == PH_NAME || phase == PH_ATTR);
        nt_addr = (phase == PH_NAME) ? name_addr(row, col) : group_addr(row, col);
        pt_rd   = fetch_en && (phase == PH_LO || phase == PH_HI);
        pt_addr = pat_addr(bank, tile_q, phase == PH_HI, fine);
    end

    // read data returns one cycle after each request
    always_ff @(posedge clk) begin
        if (rst) begin
            tile_q  <= '0;
            fetched <= '0;
        end else if (fetch_en) begin
            case (phase)
                PH_ATTR:  tile_q         <= nt_data;
                PH_LO:    fetched.pal    <= group_field(nt_data, row[1], col[1]);
                PH_HI:    fetched.plane0 <= pt_data;
                PH_GOTHI: fetched.plane1 <= pt_data;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/tbr_pixel.sv
module tbr_pixel
    import tbr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             emit_en,
    input  tile_row_t        fetched,
    input  logic [PAL_W-1:0] backdrop,
    input  logic [X_W-1:0]   x_pos,
    output logic             pix_valid,
    output logic [X_W-1:0]   pix_x,
    output logic [PAL_W-1:0] pix_idx
);

    tile_row_t  shift_q;
    logic [1:0] bits;

    assign bits = {shift_q.plane1[BYTE_W-1], shift_q.plane0[BYTE_W-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
        end else if (load) begin
            shift_q <= fetched;
        end else if (emit_en) begin
            shift_q.plane0 <= {shift_q.plane0[BYTE_W-2:0], 1'b0};
            shift_q.plane1 <= {shift_q.plane1[BYTE_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_valid <= 1'b0;
            pix_x     <= '0;
            pix_idx   <= '0;
        end else begin
            pix_valid <= emit_en;
            if (emit_en) begin
                pix_x   <= x_pos;
                pix_idx <= (bits == 2'b00) ? backdrop : {shift_q.pal, bits};
            end
        end
    end

endmodule

// File: rtl/tile_bg_render.sv
module tile_bg_render
    import tbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [Y_W-1:0]    line_y,
    input  logic              pat_sel,
    input  logic [PAL_W-1:0]  backdrop,
    output logic              nt_rd,
    output logic [NT_AW-1:0]  nt_addr,
    input  logic [BYTE_W-1:0] nt_data,
    output logic              pt_rd,
    output logic [PT_AW-1:0]  pt_addr,
    input  logic [BYTE_W-1:0] pt_data,
    output logic              busy,
    output logic              pix_valid,
    output logic [X_W-1:0]    pix_x,
    output logic [PAL_W-1:0]  pix_idx
);

    logic             run, go, fetch_en, emit_en, load;
    logic [CNT_W-1:0] cnt;
    logic [PH_W-1:0]  phase;
    logic [COL_W-1:0] col;
    logic [Y_W-1:0]   line_q;
    logic             bank_q;
    logic [PAL_W-1:0] bd_q;
    tile_row_t        fetched;

    assign busy = run | pix_valid;
    assign go   = start & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
            bank_q <= 1'b0;
            bd_q   <= '0;
        end else if (go) begin
            line_q <= line_y;
            bank_q <= pat_sel;
            bd_q   <= backdrop;
        end
    end

    tbr_seq seq_i (
        .clk(clk), .rst(rst), .go(go), .run(run), .cnt(cnt),
        .fetch_en(fetch_en), .phase(phase), .col(col),
        .emit_en(emit_en), .load(load)
    );

    tbr_fetch fetch_i (
        .clk(clk), .rst(rst), .fetch_en(fetch_en), .phase(phase), .col(col),
        .row(ROW_W'(line_q >> PH_W)), .fine(line_q[PH_W-1:0]), .bank(bank_q),
        .nt_rd(nt_rd), .nt_addr(nt_addr), .nt_data(nt_data),
        .pt_rd(pt_rd), .pt_addr(pt_addr), .pt_data(pt_data),
        .fetched(fetched)
    );

    tbr_pixel pixel_i (
        .clk(clk), .rst(rst), .load(load), .emit_en(emit_en),
        .fetched(fetched), .backdrop(bd_q),
        .x_pos(X_W'(cnt - CNT_W'(TILE_PX))),
        .pix_valid(pix_valid), .pix_x(pix_x), .pix_idx(pix_idx)
    );

endmodule

// File: rtl/tbr_chk.sv
module tbr_chk
    import tbr_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           busy,
    input logic           pix_valid,
    input logic [X_W-1:0] pix_x,
    input logic           nt_rd,
    input logic           pt_rd,
    input logic [Y_W-1:0] line_q
);

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    always @(negedge clk) begin
        if (rst_d && rst)
            assert_reset_idle_R1: assert (!pix_valid && !busy && !nt_rd && !pt_rd);
    end

    assert_first_pixel_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(pix_valid) |-> pix_x == '0);

    assert_no_gap_R2: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && pix_x != {X_W{1'b1}}) |=> (pix_valid && pix_x == $past(pix_x) + X_W'(1)));

    assert_line_held_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(line_q)));

    assert_ports_apart_R8: assert property (@(posedge clk) disable iff (rst)
        !(nt_rd && pt_rd));

    assert_pattern_follows_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(nt_rd) |-> pt_rd);

endmodule

bind tile_bg_render tbr_chk chk_i (
    .clk(clk), .rst(rst), .busy(busy), .pix_valid(pix_valid), .pix_x(pix_x),
    .nt_rd(nt_rd), .pt_rd(pt_rd), .line_q(line_q)
);

// File: tb/tile_bg_render_tb.sv
`timescale 1ns/1ps
module tile_bg_render_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  line_y = '0;
    logic        pat_sel = 1'b0;
    logic [3:0]  backdrop = '0;
    logic        nt_rd, pt_rd, busy, pix_valid;
    logic [9:0]  nt_addr;
    logic [12:0] pt_addr;
    logic [7:0]  nt_data = '0, pt_data = '0, pix_x;
    logic [3:0]  pix_idx;

    int checks = 0;
    int fails = 0;
    int nt_cnt = 0;
    int pt_cnt = 0;
    int clear_px = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tile_bg_render dut_i (
        .clk(clk), .rst(rst), .start(start), .line_y(line_y), .pat_sel(pat_sel),
        .backdrop(backdrop), .nt_rd(nt_rd), .nt_addr(nt_addr), .nt_data(nt_data),
        .pt_rd(pt_rd), .pt_addr(pt_addr), .pt_data(pt_data), .busy(busy),
        .pix_valid(pix_valid), .pix_x(pix_x), .pix_idx(pix_idx)
    );

    function automatic logic [7:0] ntf(input logic [9:0] a);
        logic [15:0] h;
        h = 16'(a) * 16'd37 + 16'(a >> 3) * 16'd5 + 16'd3;
        return h[7:0] ^ h[11:4];
    endfunction

    function automatic logic [7:0] ptf(input logic [12:0] a);
        logic [15:0] h;
        h = 16'(a) * 16'd151 + 16'(a >> 4) * 16'd7 + 16'd13;
        return h[7:0] ^ h[13:6];
    endfunction

    always @(posedge clk) begin
        if (nt_rd) begin
            nt_data <= ntf(nt_addr);
            nt_cnt  <= nt_cnt + 1;
        end
        if (pt_rd) begin
            pt_data <= ptf(pt_addr);
            pt_cnt  <= pt_cnt + 1;
        end
    end

    function automatic logic [3:0] model(input int x, input int y, input logic sel,
                                         input logic [3:0] bd);
        int c, r, fy, sh;
        logic [7:0] t, g, lo, hi;
        logic b0, b1;
        c  = x / 8;
        r  = y / 8;
        fy = y % 8;
        t  = ntf(10'(r * 32 + c));
        g  = ntf(10'(960 + (r / 4) * 8 + c / 4));
        sh = ((r >> 1) & 1) * 4 + ((c >> 1) & 1) * 2;
        lo = ptf(13'(int'(sel) * 4096 + int'(t) * 16 + fy));
        hi = ptf(13'(int'(sel) * 4096 + int'(t) * 16 + fy + 8));
        b0 = lo[7 - (x % 8)];
        b1 = hi[7 - (x % 8)];
        if (!b0 && !b1) return bd;
        return {g[sh+1], g[sh], b1, b0};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_line(input logic [7:0] y, input logic sel, input logic [3:0] bd,
                            input bit poke);
        int nt0, pt0, bad_t, first_bad;
        @(negedge clk);
        line_y = y; pat_sel = sel; backdrop = bd; start = 1'b1;
        nt0 = nt_cnt; pt0 = pt_cnt;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R2 busy after start", int'(busy), 1);
        bad_t = 0; first_bad = -1;
        for (int k = 0; k <= 266; k++) begin
            bit ev;
            if (k > 0) @(negedge clk);
            if (poke && k == 40) begin
                // R7: restart attempt with other line, bank and backdrop
                start = 1'b1; line_y = y ^ 8'h55; pat_sel = ~sel; backdrop = ~bd;
            end
            if (poke && k == 41) start = 1'b0;
            ev = (k >= 9 && k <= 264);
            if (pix_valid !== ev || (ev && pix_x !== 8'(k - 9))) begin
                bad_t++;
                if (first_bad < 0) first_bad = k;
            end
            if (ev) begin
                logic [3:0] e;
                e = model(k - 9, y, sel, bd);
                if (e == bd) clear_px++;
                check(pix_idx === e, poke ? "R7 pixel after ignored restart" :
                      "R3 R4 R5 R6 pixel index", int'(pix_idx), int'(e));
            end
        end
        check(bad_t == 0, "R2 valid window and pix_x order", first_bad, -1);
        check(busy === 1'b0, "R2 busy low after line", int'(busy), 0);
        check(nt_cnt - nt0 == 64, "R8 name port reads", nt_cnt - nt0, 64);
        check(pt_cnt - pt0 == 64, "R8 pattern port reads", pt_cnt - pt0, 64);
    endtask

    localparam logic [12:0] VECS [0:5] = '{
        {8'd0,   1'b0, 4'hD},
        {8'd7,   1'b1, 4'h5},
        {8'd17,  1'b0, 4'hB},
        {8'd100, 1'b1, 4'h7},
        {8'd239, 1'b0, 4'hE},
        {8'd58,  1'b1, 4'h0}
    };

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(pix_valid === 1'b0, "R1 pix_valid in reset", int'(pix_valid), 0);
        check(busy === 1'b0, "R1 busy in reset", int'(busy), 0);
        check(nt_rd === 1'b0, "R1 nt_rd in reset", int'(nt_rd), 0);
        check(pt_rd === 1'b0, "R1 pt_rd in reset", int'(pt_rd), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < 6; i++)
            run_line(VECS[i][12:5], VECS[i][4], VECS[i][3:0], 1'b0);

        // R7: restart and input changes during a line
        run_line(8'd137, 1'b1, 4'h9, 1'b1);

        check(clear_px > 0, "R6 transparent pixels seen", clear_px, 1);

        finished = 1'b1;
        summary();
    end

endmodule